// File: doc/BRIEF.md
# Triggered Command Set Sequencer

This block is a single command-set engine behind a small word-addressed register file. Software fills up to sixteen command slots, each with a message id, a target address and a data word. It then selects the slots to send with a command-enable mask and marks some of them in a completion-wait mask. The engine starts in two steps. One control write sets the mode-enable bit. A later write sets the trigger bit.

While it runs, the engine walks the enabled slots from the lowest index to the highest. It hands each slot to a downstream valid/ready port and records the slot as issued when the handshake takes place. Downstream responses name the slot they belong to. A response marks that slot completed and stores its response data. The set is finished once every enabled slot has been issued and every enabled slot in the wait mask has completed. At that point the engine returns to idle and sets its interrupt status bit. The interrupt pin follows that bit, gated by an interrupt-enable bit. Software clears the status bit by writing a one to a separate clear address. To disarm, software clears the trigger bit first and the enable bit in a later write.

Top module: `cmd_set_seq`

## Requirements
- R1: After reset, every writable register reads zero, the status word at 0x18 reads 1, reqValid is 0 and irq is 0.
- R2: Registers read back the value last written to them. These are interrupt enable (bit 0 at 0x00), wait mask (0x10), control (0x14) and command enable (0x1C). For slot i, the message id, address and data words sit at 0x30+20*i plus 0, 4 and 8.
- R3: A control write starts a run only when it sets trigger (bit 24), the stored trigger is 0, the stored enable (bit 16) is already 1 and the engine is idle. Setting enable and trigger in the same write arms the engine but does not start a run.
- R4: A control write that leaves enable (bit 16) at 0 while its own trigger bit is 1, or while the stored trigger is 1, is dropped as a whole.
- R5: Bit 0 of the word at 0x18 reads 0 while a run is in progress and 1 when idle.
- R6: During a run, reqValid presents the lowest enabled slot not yet issued, with its message id, address and data. A slot counts as issued on a cycle where reqValid and reqReady are both high.
- R7: The status word of slot i, at 0x30+20*i+12, has issued at bit 8 and completed at bit 16. A run start clears both. A response on respSlot marks a slot completed only if it was already issued. The response data is stored in the word at +16.
- R8: A run ends, and the interrupt status (bit 0 at 0x04) is set, once all enabled slots are issued and all enabled slots in the wait mask are completed. A run with no enabled slots ends at once.
- R9: irq equals the interrupt status ANDed with the interrupt enable. Writing a 1 to bit 0 of 0x08 clears the status. A completion in the same cycle takes priority over the clear.
- R10: Writes to 0x04 and to a slot status word leave the values read there unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 10 | Byte address for both reads and writes |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data at regAddr |
| reqValid | output | 1 | Command offered downstream |
| reqReady | input | 1 | Downstream accepts the offered command |
| reqMsgId | output | 32 | Message id of the offered command |
| reqAddr | output | 32 | Address of the offered command |
| reqData | output | 32 | Data of the offered command |
| respValid | input | 1 | Downstream completion response |
| respSlot | input | 4 | Slot the response belongs to |
| respData | input | 32 | Response data |
| irq | output | 1 | Gated interrupt |

## Verification
The most visible sign of a corrupted issued mask is the downstream port. A slot offered twice, skipped, or taken out of ascending order changes reqAddr on the very next cycle after the handshake. A wrong completion mask or a wrong wait test moves the falling edge of the busy state and the rising edge of irq by at least one cycle, and a per-cycle comparison catches either. Faults in the arm sequence or the write filter appear as a run that starts or fails to start on the cycle after the control write. They also appear in the control word when it is read back.

// File: rtl/cmd_set_pkg.sv
package cmd_set_pkg;
  localparam int SLOT_W = 4;

  localparam int OFF_IRQ_EN  = 'h00;
  localparam int OFF_IRQ_ST  = 'h04;
  localparam int OFF_IRQ_CLR = 'h08;
  localparam int OFF_WAIT    = 'h10;
  localparam int OFF_CTRL    = 'h14;
  localparam int OFF_STATUS  = 'h18;
  localparam int OFF_CMD_EN  = 'h1C;
  localparam int CMD_BASE    = 'h30;
  localparam int CMD_STRIDE  = 20;

  localparam int CTRL_EN_BIT   = 16;
  localparam int CTRL_TRIG_BIT = 24;
  localparam int ST_ISS_BIT    = 8;
  localparam int ST_CMP_BIT    = 16;

  typedef struct packed {
    logic              clrStatus;
    logic              issueFire;
    logic [SLOT_W-1:0] slot;
    logic              setDone;
  } seqStrobe_t;
endpackage

// File: rtl/cmd_set_regfile.sv
module cmd_set_regfile
  import cmd_set_pkg::*;
#(
  parameter int NUM_CMDS = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  seqStrobe_t          stb,
  input  logic                busy,
  input  logic                respValid,
  input  logic [SLOT_W-1:0]   respSlot,
  input  logic [DATA_W-1:0]   respData,
  output logic                startReq,
  output logic [NUM_CMDS-1:0] cmdEnMask,
  output logic [NUM_CMDS-1:0] waitMask,
  output logic [NUM_CMDS-1:0] issuedMask,
  output logic [NUM_CMDS-1:0] complMask,
  output logic                irqStatus,
  output logic                irq,
  output logic [DATA_W-1:0]   curMsgId,
  output logic [DATA_W-1:0]   curAddr,
  output logic [DATA_W-1:0]   curData
);
  localparam int CMD_END = CMD_BASE + CMD_STRIDE * NUM_CMDS;

  logic              irqEnR, ctrlEn, ctrlTrig;
  logic [DATA_W-1:0] msgIdR [NUM_CMDS];
  logic [DATA_W-1:0] addrR  [NUM_CMDS];
  logic [DATA_W-1:0] dataR  [NUM_CMDS];
  logic [DATA_W-1:0] respR  [NUM_CMDS];

  logic              isCmd;
  logic [ADDR_W-1:0] cmdOff;
  logic [SLOT_W-1:0] cmdIdx;
  logic [2:0]        cmdWord;
  logic              ctrlWr, ctrlAccept, respHit;

  always_comb begin
    isCmd   = (int'(regAddr) >= CMD_BASE) && (int'(regAddr) < CMD_END) && (regAddr[1:0] == 2'b00);
    cmdOff  = regAddr - ADDR_W'(CMD_BASE);
    cmdIdx  = SLOT_W'(cmdOff / ADDR_W'(CMD_STRIDE));
    cmdWord = 3'((cmdOff % ADDR_W'(CMD_STRIDE)) >> 2);
  end

  assign ctrlWr     = regWrEn && (regAddr == ADDR_W'(OFF_CTRL));
  assign ctrlAccept = regWrData[CTRL_EN_BIT] || !(regWrData[CTRL_TRIG_BIT] || ctrlTrig);
  assign startReq   = ctrlWr && ctrlAccept && regWrData[CTRL_TRIG_BIT] && !ctrlTrig && ctrlEn && !busy;
  assign respHit    = respValid && (int'(respSlot) < NUM_CMDS) && issuedMask[respSlot];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEnR <= 1'b0; ctrlEn <= 1'b0; ctrlTrig <= 1'b0; irqStatus <= 1'b0;
      waitMask <= '0; cmdEnMask <= '0; issuedMask <= '0; complMask <= '0;
      for (int i = 0; i < NUM_CMDS; i++) begin
        msgIdR[i] <= '0; addrR[i] <= '0; dataR[i] <= '0; respR[i] <= '0;
      end
    end else begin
      if (regWrEn) begin
        if (regAddr == ADDR_W'(OFF_IRQ_EN)) irqEnR <= regWrData[0];
        if (regAddr == ADDR_W'(OFF_WAIT))   waitMask <= regWrData[NUM_CMDS-1:0];
        if (regAddr == ADDR_W'(OFF_CMD_EN)) cmdEnMask <= regWrData[NUM_CMDS-1:0];
        if (ctrlWr && ctrlAccept) begin
          ctrlEn   <= regWrData[CTRL_EN_BIT];
          ctrlTrig <= regWrData[CTRL_TRIG_BIT];
        end
        if (isCmd) begin
          case (cmdWord)
            3'd0:    msgIdR[cmdIdx] <= regWrData;
            3'd1:    addrR[cmdIdx]  <= regWrData;
            3'd2:    dataR[cmdIdx]  <= regWrData;
            default: ;
          endcase
        end
      end
      if (stb.clrStatus) begin
        issuedMask <= '0;
        complMask  <= '0;
      end else begin
        if (stb.issueFire) issuedMask[stb.slot] <= 1'b1;
        if (respHit) begin
          complMask[respSlot] <= 1'b1;
          respR[respSlot]     <= respData;
        end
      end
      if (stb.setDone) irqStatus <= 1'b1;
      else if (regWrEn && regAddr == ADDR_W'(OFF_IRQ_CLR) && regWrData[0]) irqStatus <= 1'b0;
    end
  end

  assign irq      = irqStatus && irqEnR;
  assign curMsgId = msgIdR[stb.slot];
  assign curAddr  = addrR[stb.slot];
  assign curData  = dataR[stb.slot];

  always_comb begin
    regRdData = '0;
    if (isCmd) begin
      case (cmdWord)
        3'd0: regRdData = msgIdR[cmdIdx];
        3'd1: regRdData = addrR[cmdIdx];
        3'd2: regRdData = dataR[cmdIdx];
        3'd3: begin
          regRdData[ST_ISS_BIT] = issuedMask[cmdIdx];
          regRdData[ST_CMP_BIT] = complMask[cmdIdx];
        end
        default: regRdData = respR[cmdIdx];
      endcase
    end else begin
      case (int'(regAddr))
        OFF_IRQ_EN: regRdData[0] = irqEnR;
        OFF_IRQ_ST: regRdData[0] = irqStatus;
        OFF_WAIT:   regRdData[NUM_CMDS-1:0] = waitMask;
        OFF_CTRL: begin
          regRdData[CTRL_EN_BIT]   = ctrlEn;
          regRdData[CTRL_TRIG_BIT] = ctrlTrig;
        end
        OFF_STATUS: regRdData[0] = !busy;
        OFF_CMD_EN: regRdData[NUM_CMDS-1:0] = cmdEnMask;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cmd_set_ctrl.sv
module cmd_set_ctrl
  import cmd_set_pkg::*;
#(
  parameter int NUM_CMDS = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic [NUM_CMDS-1:0] cmdEnMask,
  input  logic [NUM_CMDS-1:0] waitMask,
  input  logic [NUM_CMDS-1:0] issuedMask,
  input  logic [NUM_CMDS-1:0] complMask,
  input  logic                reqReady,
  output logic                reqValid,
  output logic                busy,
  output seqStrobe_t          stb
);
  typedef enum logic {S_IDLE, S_RUN} seqState_t;
  seqState_t state;

  logic [NUM_CMDS-1:0] pending;
  logic [SLOT_W-1:0]   nextSlot;
  logic                waitOpen;

  assign pending  = cmdEnMask & ~issuedMask;
  assign waitOpen = |(waitMask & cmdEnMask & ~complMask);
  assign busy     = (state == S_RUN);
  assign reqValid = busy && |pending;

  always_comb begin
    nextSlot = '0;
    for (int i = NUM_CMDS - 1; i >= 0; i--) begin
      if (pending[i]) nextSlot = SLOT_W'(i);
    end
  end

  always_comb begin
    stb.clrStatus = (state == S_IDLE) && startReq;
    stb.issueFire = reqValid && reqReady;
    stb.slot      = nextSlot;
    stb.setDone   = busy && !(|pending) && !waitOpen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else if (stb.clrStatus) state <= S_RUN;
    else if (stb.setDone) state <= S_IDLE;
  end
endmodule

// File: rtl/cmd_set_seq.sv
module cmd_set_seq
  import cmd_set_pkg::*;
#(
  parameter int NUM_CMDS = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [DATA_W-1:0] reqMsgId,
  output logic [DATA_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqData,
  input  logic              respValid,
  input  logic [SLOT_W-1:0] respSlot,
  input  logic [DATA_W-1:0] respData,
  output logic              irq
);
  seqStrobe_t          stb;
  logic                busy, startReq, irqStatus;
  logic [NUM_CMDS-1:0] cmdEnMask, waitMask, issuedMask, complMask;

  cmd_set_regfile #(.NUM_CMDS(NUM_CMDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .stb(stb), .busy(busy), .respValid(respValid),
    .respSlot(respSlot), .respData(respData), .startReq(startReq), .cmdEnMask(cmdEnMask),
    .waitMask(waitMask), .issuedMask(issuedMask), .complMask(complMask),
    .irqStatus(irqStatus), .irq(irq), .curMsgId(reqMsgId), .curAddr(reqAddr), .curData(reqData)
  );

  cmd_set_ctrl #(.NUM_CMDS(NUM_CMDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmdEnMask(cmdEnMask), .waitMask(waitMask),
    .issuedMask(issuedMask), .complMask(complMask), .reqReady(reqReady),
    .reqValid(reqValid), .busy(busy), .stb(stb)
  );
endmodule

// File: rtl/cmd_set_seq_checker.sv
module cmd_set_seq_checker #(
  parameter int NUM_CMDS = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                busy,
  input logic                irqStatus,
  input logic [NUM_CMDS-1:0] issuedMask,
  input logic [NUM_CMDS-1:0] complMask
);
  AST_REQ_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> busy); // R6
  AST_START_CLEARS_ISSUED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (issuedMask == '0)); // R7
  AST_COMPL_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    (complMask & ~issuedMask) == '0); // R7
  AST_END_SETS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> irqStatus); // R8
  AST_STATUS_FROM_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqStatus) |-> $past(busy)); // R8
endmodule

bind cmd_set_seq cmd_set_seq_checker #(.NUM_CMDS(NUM_CMDS)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .busy(busy), .irqStatus(irqStatus),
  .issuedMask(issuedMask), .complMask(complMask)
);

// File: tb/cmd_set_seq_bench.sv
module cmd_set_seq_bench;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [9:0]  regAddr;
  logic [31:0] regWrData, regRdData;
  logic        reqValid, reqReady;
  logic [31:0] reqMsgId, reqAddr, reqData;
  logic        respValid;
  logic [3:0]  respSlot;
  logic [31:0] respData;
  logic        irq;

  always #10 clk = ~clk;

  cmd_set_seq u_cmd_set_seq (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .reqValid(reqValid), .reqReady(reqReady), .reqMsgId(reqMsgId),
    .reqAddr(reqAddr), .reqData(reqData), .respValid(respValid), .respSlot(respSlot),
    .respData(respData), .irq(irq)
  );

  int tests = 0, fails = 0, cyc = 0, readyMode = 1;
  bit finished = 0;

  logic        mBusy, mIrqSt, mIrqEn, mEn, mTrig;
  logic [15:0] mCmdEn, mWait, mIss, mCmp;
  logic [31:0] tAddr [N], tData [N], tMsg [N];
  int          rq[$], rqDue[$];

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int lowest(logic [15:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [9:0] cmdA(int i, int w);
    return 10'(48 + 20 * i + 4 * w);
  endfunction

  // behavioural reference, advanced on each rising edge from stable inputs
  always @(posedge clk) begin
    int  p;
    bit  hs, done, acc;
    cyc++;
    if (!rstN) begin
      mBusy <= 0; mIrqSt <= 0; mIrqEn <= 0; mEn <= 0; mTrig <= 0;
      mCmdEn <= 0; mWait <= 0; mIss <= 0; mCmp <= 0;
    end else begin
      p    = lowest(mCmdEn & ~mIss);
      hs   = mBusy && p >= 0 && reqReady;
      done = mBusy && p < 0 && ((mWait & mCmdEn & ~mCmp) == 0);
      if (hs) begin rq.push_back(p); rqDue.push_back(cyc + 3); end
      if (regWrEn) begin
        case (int'(regAddr))
          'h00: mIrqEn <= regWrData[0];
          'h08: if (regWrData[0] && !done) mIrqSt <= 0;
          'h10: mWait <= regWrData[15:0];
          'h1C: mCmdEn <= regWrData[15:0];
          'h14: begin
            acc = regWrData[16] || !(regWrData[24] || mTrig);
            if (acc) begin mEn <= regWrData[16]; mTrig <= regWrData[24]; end
            if (acc && regWrData[24] && !mTrig && mEn && !mBusy) begin
              mBusy <= 1; mIss <= 0; mCmp <= 0;
            end
          end
          default: ;
        endcase
      end
      if (!(regWrEn && regAddr == 10'h14 && mBusy == 0 && mEn && !mTrig && regWrData[24] && regWrData[16])) begin
        if (hs) mIss[p] <= 1;
        if (respValid && mIss[respSlot]) mCmp[respSlot] <= 1;
      end
      if (done) begin mBusy <= 0; mIrqSt <= 1; end
    end
  end

  // per-cycle comparison away from the clock edge
  always @(negedge clk) begin
    int p;
    if (rstN === 1'b1 && !finished) begin
      p = lowest(mCmdEn & ~mIss);
      chk(reqValid === (mBusy && p >= 0), "R6 reqValid", 32'(reqValid), 32'(mBusy && p >= 0));
      if (mBusy && p >= 0) begin
        chk(reqAddr === tAddr[p], "R6 reqAddr order", reqAddr, tAddr[p]);
        chk(reqData === tData[p] && reqMsgId === tMsg[p], "R6 reqData/msgId", reqData, tData[p]);
      end
      chk(irq === (mIrqSt && mIrqEn), "R9 irq", 32'(irq), 32'(mIrqSt && mIrqEn));
    end
  end

  // downstream model: ready pattern and delayed responses
  initial begin
    respValid = 0; respSlot = 0; respData = 0; reqReady = 0;
    forever begin
      @(posedge clk); #5;
      respValid = 0;
      if (rq.size() > 0 && rqDue[0] <= cyc) begin
        respValid = 1; respSlot = 4'(rq[0]); respData = 32'hA000 + 32'(rq[0]);
        void'(rq.pop_front()); void'(rqDue.pop_front());
      end
      reqReady = (readyMode == 1) ? 1'b1 : (readyMode == 2) ? ($urandom % 3 != 0) : 1'b0;
    end
  end

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(posedge clk); #5;
    regWrEn = 1; regAddr = a; regWrData = d;
    @(posedge clk); #5;
    regWrEn = 0;
  endtask

  task automatic rd(logic [9:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #5;
    regAddr = a; #1;
    chk(regRdData === exp, tag, regRdData, exp);
  endtask

  task automatic waitIdle();
    int n = 0;
    while (mBusy && n < 300) begin @(posedge clk); n++; end
    chk(!mBusy, "R8 run did not end", 32'(mBusy), 0);
    repeat (8) @(posedge clk);
  endtask

  task automatic arm();
    wr(10'h14, 32'h0001_0000);
    wr(10'h14, 32'h0101_0000);
  endtask

  task automatic disarm();
    wr(10'h14, 32'h0001_0000);
    wr(10'h14, 32'h0000_0000);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1; tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rstN = 0; regWrEn = 0; regAddr = 0; regWrData = 0;
    for (int i = 0; i < N; i++) begin
      tAddr[i] = 32'h1000 + 32'(i);
      tData[i] = 32'h5000 + 32'(i * 7);
      tMsg[i]  = 32'h0001_0008 | ((i % 2) ? 32'h100 : 32'h0);
    end
    repeat (3) @(posedge clk); #5; rstN = 1;

    // R1 reset state
    chk(reqValid === 0 && irq === 0, "R1 outputs after reset", {reqValid, irq}, 0);
    rd(10'h18, 32'h1, "R1 status idle");
    rd(10'h14, 32'h0, "R1 control");
    rd(10'h1C, 32'h0, "R1 command enable");
    rd(10'h04, 32'h0, "R1 interrupt status");

    // R2 load and read back
    for (int i = 0; i < N; i++) begin
      wr(cmdA(i, 0), tMsg[i]); wr(cmdA(i, 1), tAddr[i]); wr(cmdA(i, 2), tData[i]);
    end
    rd(cmdA(3, 0), tMsg[3], "R2 msgid slot3");
    rd(cmdA(9, 1), tAddr[9], "R2 addr slot9");
    rd(cmdA(15, 2), tData[15], "R2 data slot15");
    wr(10'h00, 32'h1); rd(10'h00, 32'h1, "R2 irq enable");
    wr(10'h10, 32'h0084); rd(10'h10, 32'h0084, "R2 wait mask");
    wr(10'h1C, 32'h00A5); rd(10'h1C, 32'h00A5, "R2 command enable");

    // R6/R7/R8 ascending run with waited slots 2 and 7
    readyMode = 2;
    arm();
    rd(10'h18, 32'h0, "R5 status busy");
    rd(10'h14, 32'h0101_0000, "R2 control armed");
    waitIdle();
    rd(10'h18, 32'h1, "R5 status idle after run");
    rd(10'h04, 32'h1, "R8 interrupt status set");
    chk(irq === 1, "R9 irq enabled", 32'(irq), 1);
    rd(cmdA(2, 3), 32'h0001_0100, "R7 slot2 issued+completed");
    rd(cmdA(1, 3), 32'h0, "R7 disabled slot1 untouched");
    rd(cmdA(7, 4), 32'hA007, "R7 slot7 response data");

    // R9 clear
    wr(10'h08, 32'h1);
    rd(10'h04, 32'h0, "R9 status cleared");

    // R4 filtered control writes
    wr(10'h14, 32'h0); rd(10'h14, 32'h0101_0000, "R4 enable cleared before trigger dropped");
    wr(10'h14, 32'h0100_0000); rd(10'h14, 32'h0101_0000, "R4 trigger without enable dropped");
    wr(10'h14, 32'h0001_0000); rd(10'h14, 32'h0001_0000, "R4 trigger cleared first");
    wr(10'h14, 32'h0); rd(10'h14, 32'h0, "R4 enable cleared second");

    // R3 enable and trigger together: armed, no run
    wr(10'h14, 32'h0101_0000);
    rd(10'h18, 32'h1, "R3 no start on combined write");
    rd(10'h14, 32'h0101_0000, "R3 combined write stored");
    repeat (4) @(posedge clk);
    disarm();

    // R8 run with no enabled slot
    readyMode = 1;
    wr(10'h1C, 32'h0);
    arm();
    waitIdle();
    rd(10'h04, 32'h1, "R8 empty run completes");
    disarm();
    wr(10'h08, 32'h1);

    // R9 gated by enable, R10 ignored writes
    wr(10'h00, 32'h0);
    wr(10'h1C, 32'h8000); wr(10'h10, 32'h8000);
    arm();
    waitIdle();
    chk(irq === 0, "R9 irq masked", 32'(irq), 0);
    rd(10'h04, 32'h1, "R9 status set while masked");
    wr(10'h04, 32'h0); rd(10'h04, 32'h1, "R10 status write ignored");
    wr(cmdA(15, 3), 32'h0); rd(cmdA(15, 3), 32'h0001_0100, "R10 slot status write ignored");
    disarm();

    // full set, all waited, ready always high
    wr(10'h1C, 32'hFFFF); wr(10'h10, 32'hFFFF); wr(10'h08, 32'h1);
    arm();
    waitIdle();
    rd(cmdA(0, 3), 32'h0001_0100, "R7 slot0 after full run");
    rd(10'h04, 32'h1, "R8 full run complete");

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule